// File: doc/BRIEF.md
# Proximity Tag Frame Checker

The block takes the demodulated bit stream of a low-frequency proximity tag reader, one bit per strobe, and looks for a 64-bit tag message at every bit position. A message opens with a run of zero bits and a fixed sync byte. After that come byte-wide fields, each closed by a single 1 bit, and the message ends on two 1 bits. When the framing matches, the block pulses a found flag for one cycle. In the same cycle it presents the facility, version, card number and the checksum carried in the message. It also reports whether that checksum agrees with the one it recomputes from the message.

The checksum is the one's complement of the low byte of the sum of the sync byte and the four data bytes. The reader logic downstream can take the fields on the found pulse and drop any message whose checksum flag is low.

Top module: `prox_frame_chk`

## Requirements
- R1: Take offset 0 as the first bit received. A frame is recognised in either case below: the 64 most recent accepted bits have zeros at offsets 0..8, byte 0xF0 at offsets 9..16, 1 bits at offsets 17, 26, 35, 44, 53 and 62, and a 1 bit at offset 63. When this holds, `frame_o` is high for exactly one cycle, the cycle after the clock edge that accepts the bit at offset 63.
- R2: Detection is tested at every bit position, so a frame preceded by any number of unrelated bits is still found.
- R3: On a found frame, `facility_o` is the byte at offsets 18..25 and `version_o` is the byte at offsets 27..34. Each byte is taken with its first-received bit as its most significant bit.
- R4: On a found frame, `number_o` is the byte at offsets 36..43 as bits 15:8, joined with the byte at offsets 45..52 as bits 7:0.
- R5: On a found frame, `crc_rx_o` is the byte at offsets 54..61.
- R6: `crc_ok_o` is high together with `frame_o` when the received checksum equals 0xFF minus the low 8 bits of the sum of the bytes at offsets 9, 18, 27, 36 and 45. For example, the bytes F0, E0, 01, 03, B6 give 0x75.
- R7: When the checksums differ, the frame is still reported and `crc_ok_o` is low.
- R8: A stream with a wrong sync byte, a 1 in the zero run, or a 0 in any separator or end bit produces no `frame_o`.
- R9: After reset, no frame is reported until 64 bits have been accepted, even if fewer bits would complete the pattern over the cleared window.
- R10: Values on `bit_i` in cycles where `bit_vld_i` is low are ignored and do not shift the window.
- R11: During and after reset, all outputs are zero until a frame is found.
- R12: The field outputs and `crc_ok_o` hold their values until the next found frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Strobe: `bit_i` carries a new stream bit |
| bit_i | input | 1 | Demodulated data bit |
| frame_o | output | 1 | One-cycle pulse on a found frame |
| facility_o | output | 8 | Facility code of the last frame |
| version_o | output | 8 | Version byte of the last frame |
| number_o | output | 16 | Card number of the last frame |
| crc_rx_o | output | 8 | Received checksum of the last frame |
| crc_ok_o | output | 1 | Received checksum matched the computed one |

## Verification
A table of field sets is framed and streamed back to back. The table mixes sets whose checksum matches with sets whose checksum does not, and includes all-zero and all-one data bytes, so that field placement, byte order and checksum arithmetic are told apart. The patterns that follow each target one rule:
- A frame behind a few stray bits shows that detection runs at every offset.
- Copies with one broken sync, zero-run or separator bit show that each framing test is active. They also show that the held fields stay put.
- A partial frame streamed right after reset tests the fill rule.
- A frame interrupted by idle cycles with a toggling data line tests that only strobed bits are accepted.

// File: rtl/prox_frame_chk_pkg.sv
package prox_frame_chk_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/prox_frame_chk_window.sv
module prox_frame_chk_window #(
  parameter int unsigned LEN = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bit_vld_i,
  input  logic           bit_i,
  output logic [LEN-1:0] win_d_o,
  output logic           full_d_o,
  output logic           full_q_o
);
  localparam int unsigned CNT_W = $clog2(LEN + 1);

  logic [LEN-1:0]   win_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // newest bit enters at bit 0; oldest sits at LEN-1
  always_comb begin
    win_d_o = win_q;
    cnt_d   = cnt_q;
    if (bit_vld_i) begin
      win_d_o = {win_q[LEN-2:0], bit_i};
      if (cnt_q != CNT_W'(LEN)) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  assign full_d_o = (cnt_d == CNT_W'(LEN));
  assign full_q_o = (cnt_q == CNT_W'(LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
    end else begin
      win_q <= win_d_o;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/prox_frame_chk_slicer.sv
module prox_frame_chk_slicer
  import prox_frame_chk_pkg::*;
#(
  parameter int unsigned LEN        = 64,
  parameter int unsigned LEAD_ZEROS = 9,
  parameter int unsigned SLOT_W     = 9,
  parameter int unsigned N_SLOTS    = 6,
  parameter byte_t       SYNC_BYTE  = 8'hF0
) (
  input  logic [LEN-1:0]             win_i,
  output logic [N_SLOTS-1:0][BYTE_W-1:0] slots_o,
  output logic                       frame_ok_o
);
  logic [N_SLOTS-1:0] sep_ok;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    localparam int unsigned OFF = LEAD_ZEROS + SLOT_W * i;
    assign slots_o[i] = win_i[LEN-1-OFF -: BYTE_W];
    assign sep_ok[i]  = win_i[LEN-1-(OFF+BYTE_W)];
  end

  assign frame_ok_o = (win_i[LEN-1 -: LEAD_ZEROS] == '0) &&
                      (slots_o[0] == SYNC_BYTE) &&
                      (&sep_ok) && win_i[0];
endmodule

// File: rtl/prox_frame_chk_sum.sv
module prox_frame_chk_sum
  import prox_frame_chk_pkg::*;
#(
  parameter int unsigned N_SLOTS = 6,
  parameter int unsigned N_SUM   = 5
) (
  input  logic [N_SLOTS-1:0][BYTE_W-1:0] slots_i,
  output byte_t                          crc_exp_o
);
  byte_t acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N_SUM; i++) acc = acc + slots_i[i];
    crc_exp_o = ~acc; // 0xFF - acc
  end
endmodule

// File: rtl/prox_frame_chk.sv
module prox_frame_chk
  import prox_frame_chk_pkg::*;
#(
  parameter int unsigned FRAME_LEN  = 64,
  parameter int unsigned LEAD_ZEROS = 9,
  parameter int unsigned SLOT_W     = 9,
  parameter int unsigned N_SLOTS    = 6,
  parameter int unsigned N_SUM      = 5,
  parameter byte_t       SYNC_BYTE  = 8'hF0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bit_vld_i,
  input  logic        bit_i,
  output logic        frame_o,
  output logic [7:0]  facility_o,
  output logic [7:0]  version_o,
  output logic [15:0] number_o,
  output logic [7:0]  crc_rx_o,
  output logic        crc_ok_o
);
  localparam int unsigned FAC_IDX = 1;
  localparam int unsigned VER_IDX = 2;
  localparam int unsigned NHI_IDX = 3;
  localparam int unsigned NLO_IDX = 4;
  localparam int unsigned CRC_IDX = N_SLOTS - 1;

  logic [FRAME_LEN-1:0]              win_d;
  logic                              full_d, full_q;
  logic [N_SLOTS-1:0][BYTE_W-1:0]    slots;
  logic                              frame_ok;
  byte_t                             crc_exp;
  logic                              hit;

  prox_frame_chk_window #(.LEN(FRAME_LEN)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld_i),
    .bit_i     (bit_i),
    .win_d_o   (win_d),
    .full_d_o  (full_d),
    .full_q_o  (full_q)
  );

  prox_frame_chk_slicer #(
    .LEN        (FRAME_LEN),
    .LEAD_ZEROS (LEAD_ZEROS),
    .SLOT_W     (SLOT_W),
    .N_SLOTS    (N_SLOTS),
    .SYNC_BYTE  (SYNC_BYTE)
  ) u_slicer (
    .win_i      (win_d),
    .slots_o    (slots),
    .frame_ok_o (frame_ok)
  );

  prox_frame_chk_sum #(.N_SLOTS(N_SLOTS), .N_SUM(N_SUM)) u_sum (
    .slots_i   (slots),
    .crc_exp_o (crc_exp)
  );

  assign hit = bit_vld_i && full_d && frame_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o    <= 1'b0;
      facility_o <= '0;
      version_o  <= '0;
      number_o   <= '0;
      crc_rx_o   <= '0;
      crc_ok_o   <= 1'b0;
    end else begin
      frame_o <= hit;
      if (hit) begin
        facility_o <= slots[FAC_IDX];
        version_o  <= slots[VER_IDX];
        number_o   <= {slots[NHI_IDX], slots[NLO_IDX]};
        crc_rx_o   <= slots[CRC_IDX];
        crc_ok_o   <= (slots[CRC_IDX] == crc_exp);
      end
    end
  end
endmodule

// File: rtl/prox_frame_chk_sva.sv
module prox_frame_chk_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bit_vld_i,
  input logic        full_q,
  input logic        frame_o,
  input logic [7:0]  facility_o,
  input logic [7:0]  version_o,
  input logic [15:0] number_o,
  input logic [7:0]  crc_rx_o,
  input logic        crc_ok_o
);
  assert_frame_after_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> $past(bit_vld_i));

  assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  assert_fill_before_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> full_q);

  assert_fields_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_o |-> ($stable(facility_o) && $stable(version_o) && $stable(number_o) && $stable(crc_rx_o)));

  assert_crc_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(crc_ok_o) |-> frame_o);
endmodule

bind prox_frame_chk prox_frame_chk_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_vld_i  (bit_vld_i),
  .full_q     (full_q),
  .frame_o    (frame_o),
  .facility_o (facility_o),
  .version_o  (version_o),
  .number_o   (number_o),
  .crc_rx_o   (crc_rx_o),
  .crc_ok_o   (crc_ok_o)
);

// File: tb/prox_frame_chk_tb_top.sv
module prox_frame_chk_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_vld_i = 1'b0;
  logic        bit_i = 1'b0;
  logic        frame_o, crc_ok_o;
  logic [7:0]  facility_o, version_o, crc_rx_o;
  logic [15:0] number_o;

  int n_chk = 0;
  int n_bad = 0;
  int pulses;
  logic last_hit;

  always #5 clk = ~clk;

  prox_frame_chk dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .frame_o(frame_o), .facility_o(facility_o), .version_o(version_o),
    .number_o(number_o), .crc_rx_o(crc_rx_o), .crc_ok_o(crc_ok_o)
  );

  // {facility, version, number, crc}
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {8'hE0, 8'h01, 16'h03B6, 8'h75},
    {8'h12, 8'h34, 16'hABCD, 8'h51},
    {8'h00, 8'h00, 16'h0000, 8'h0F},
    {8'hFF, 8'hFF, 16'hFFFF, 8'h00},
    {8'h55, 8'hAA, 16'h0F0F, 8'hF2},
    {8'hE0, 8'h01, 16'h03B6, 8'h74}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // frame image: bit [63-k] holds offset k
  function automatic logic [63:0] build(input logic [39:0] v);
    logic [63:0] f;
    f = {9'b0, 8'hF0, 1'b1, v[39:32], 1'b1, v[31:24], 1'b1,
         v[23:16], 1'b1, v[15:8], 1'b1, v[7:0], 2'b11};
    return f;
  endfunction

  function automatic logic exp_ok(input logic [39:0] v);
    logic [7:0] s;
    s = 8'hF0 + v[39:32] + v[31:24] + v[23:16] + v[15:8];
    return v[7:0] == (8'hFF - s);
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld_i = 1'b1;
    bit_i = b;
    @(negedge clk);
    bit_vld_i = 1'b0;
    bit_i = ~b; // idle value must not matter
    last_hit = frame_o;
    if (frame_o) pulses++;
  endtask

  task automatic send_frame(input logic [63:0] f);
    pulses = 0;
    for (int k = 63; k >= 0; k--) send_bit(f[k]);
  endtask

  task automatic check_fields(input string tag, input logic [39:0] v);
    chk({tag, " R3 facility"}, 32'(facility_o), 32'(v[39:32]));
    chk({tag, " R3 version"}, 32'(version_o), 32'(v[31:24]));
    chk({tag, " R4 number"}, 32'(number_o), 32'(v[23:8]));
    chk({tag, " R5 crc_rx"}, 32'(crc_rx_o), 32'(v[7:0]));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    bit_vld_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [63:0] f;
    do_reset();
    @(negedge clk);
    // R11: reset state
    chk("R11 outputs after reset",
        {frame_o, crc_ok_o, facility_o, version_o, crc_rx_o},
        32'h0);
    chk("R11 number after reset", 32'(number_o), 32'h0);

    // table walk: R1, R3..R7
    for (int i = 0; i < NV; i++) begin
      send_frame(build(VEC[i]));
      chk($sformatf("R1 pulse count v%0d", i), 32'(pulses), 32'd1);
      chk($sformatf("R1 pulse on last bit v%0d", i), 32'(last_hit), 32'd1);
      check_fields($sformatf("v%0d", i), VEC[i]);
      chk($sformatf("%s crc_ok v%0d", exp_ok(VEC[i]) ? "R6" : "R7", i),
          32'(crc_ok_o), 32'(exp_ok(VEC[i])));
    end

    // R2: stray bits before a frame
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_frame(build(VEC[1]));
    chk("R2 frame after stray bits", 32'(pulses), 32'd1);
    check_fields("R2", VEC[1]);

    // R8: broken sync byte, zero run, separator, end bit; R12 hold
    f = build(VEC[0]); f[63-12] = 1'b0;
    send_frame(f);
    chk("R8 bad sync byte", 32'(pulses), 32'd0);
    f = build(VEC[0]); f[63-4] = 1'b1;
    send_frame(f);
    chk("R8 one in zero run", 32'(pulses), 32'd0);
    f = build(VEC[0]); f[63-35] = 1'b0;
    send_frame(f);
    chk("R8 bad separator", 32'(pulses), 32'd0);
    f = build(VEC[0]); f[0] = 1'b0;
    send_frame(f);
    chk("R8 bad end bit", 32'(pulses), 32'd0);
    check_fields("R12 hold", VEC[1]);
    chk("R12 crc_ok hold", 32'(crc_ok_o), 32'd1);

    // R9: partial frame over cleared window after reset
    do_reset();
    f = build(VEC[0]);
    pulses = 0;
    for (int k = 54; k >= 0; k--) send_bit(f[k]);
    chk("R9 no frame before 64 bits", 32'(pulses), 32'd0);
    send_frame(build(VEC[4]));
    chk("R9 frame after fill", 32'(pulses), 32'd1);
    check_fields("R9", VEC[4]);

    // R10: idle cycles with toggling data inside a frame
    f = build(VEC[2]);
    pulses = 0;
    for (int k = 63; k >= 1; k--) send_bit(f[k]);
    for (int j = 0; j < 70; j++) begin
      @(negedge clk);
      bit_i = j[0];
      if (frame_o) pulses++;
    end
    chk("R10 no frame while idle", 32'(pulses), 32'd0);
    send_bit(f[0]);
    chk("R10 frame completes after idle", 32'(last_hit), 32'd1);
    check_fields("R10", VEC[2]);
    chk("R6 crc_ok after idle", 32'(crc_ok_o), 32'd1);

    finish_run();
  end
endmodule